// File: doc/BRIEF.md
# Dynamic Issue Scoreboard for Five Functional Units

This block is the hazard control for an in-order front end that feeds five functional units: one integer/load unit, two multipliers, one adder and one divider. An instruction stream presents one instruction at a time. Each instruction carries an operation code, a destination register and two source registers, drawn from a space of 32 registers. Each cycle the block makes three decisions. It decides whether the presented instruction may enter a unit. It decides which busy units may now read their operands. It decides which finished units may put their result back into the register file. Data values, arithmetic and memory never pass through the block. Only control and status do.

The block keeps one status record per unit. The record holds the busy flag, the operation, the destination register, both source register numbers, the producing unit of each source, and one readiness flag per source. The block also keeps a register-to-writer table that names the unit due to write each register. An instruction is held at the front while its unit is occupied or its destination already has a pending writer. Operand read waits for true data dependences to clear, so execution can start out of order. A finished unit is kept from writing while any other unit still has to read the old value of that register. Each unit's completion comes from an internal countdown that is loaded with that unit's latency when its operands are read.

The front end holds `in_valid` and the instruction steady until it sees `issue_ok`, and then presents the next instruction. This keeps issue in program order.

Top module: `sb_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, every unit is idle, no read or write grant is raised, and every register reports writer code 0 (none) on the query port.
- R2: An instruction issues (`issue_ok` high) only if its target unit is not busy. Otherwise it is held and nothing later can issue. The unit that accepts an issue shows busy from the next cycle on.
- R3: An instruction whose destination register has a pending writer does not issue. This includes a writer whose write-back happens in the same cycle.
- R4: Operation codes map to units as follows. Codes 0 (load) and 1 (integer) go to unit 0 (integer). Codes 2 (add) and 3 (subtract) go to unit 3 (adder). Code 4 (multiply) goes to unit 1 if it is free, otherwise to unit 2. Code 5 (divide) goes to unit 4. Codes 6 and 7 never issue. `issue_unit` shows the chosen unit when `issue_ok` is high.
- R5: A busy unit gets `rd_grant` in each cycle in which both of its readiness flags are set. The grant clears both flags, so a unit reads exactly once. The earliest read is the cycle after issue.
- R6: A unit may write back no earlier than L cycles after its read grant. L is 1 for integer, 2 for add, 10 for each multiplier and 40 for divide. It writes exactly then unless R7 holds it.
- R7: A finished unit does not get `wr_grant` while another busy unit names its destination register as a source whose readiness flag is still set.
- R8: On write-back the unit becomes idle. The register's writer entry returns to 0. Every unit waiting on that writer for a source gets that readiness flag set. The query port reports the writer code (unit index + 1, or 0) of any register.
- R9: If an instruction issues in the same cycle that the producer of one of its sources writes back, that source is recorded as ready at once.
- R10: Several units may write back in the same cycle. A unit never writes back while one of its readiness flags is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 3 | Operation code (see R4) |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| issue_ok | output | 1 | Presented instruction is accepted this cycle |
| issue_unit | output | 3 | Unit index chosen for the presented instruction |
| rd_grant | output | 5 | Per unit: operand read granted this cycle |
| wr_grant | output | 5 | Per unit: write-back granted this cycle |
| unit_busy | output | 5 | Per unit busy flag |
| ready_j | output | 5 | Per unit readiness flag of the first source |
| ready_k | output | 5 | Per unit readiness flag of the second source |
| qry_reg | input | 5 | Register whose pending writer is queried |
| qry_writer | output | 3 | Writer code of `qry_reg`: 0 none, else unit index + 1 |

## Verification
The directed program has several targets. A divide waits on a long multiply while the adder finishes a write to the divide's other source register, which sets up the WAR case. A design without the WAR check would let the adder overwrite that register before the divide reads it. A later integer op targets the divide's destination, which tests WAW blocking. A missing WAW check would let two writers race for one register. A second multiply lands in the spare multiplier, and a selector that ignored unit 2 would stall needlessly. A multiply issues in exactly the cycle its integer producer writes back. A design without the same-cycle wakeup would leave that source waiting forever, and the run would hang. Random streams over a small register set then raise simultaneous write-backs and structural stalls in bulk.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int NUM_UNITS = 5;
  localparam int NUM_REGS  = 32;
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int UIDX_W    = $clog2(NUM_UNITS);
  localparam int TAG_W     = $clog2(NUM_UNITS + 1);
  localparam int OP_W      = 3;
  localparam int NLOOK     = 4;

  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [UIDX_W-1:0] uidx_t;

  localparam uidx_t U_INT  = 3'd0;
  localparam uidx_t U_MUL1 = 3'd1;
  localparam uidx_t U_MUL2 = 3'd2;
  localparam uidx_t U_ADD  = 3'd3;
  localparam uidx_t U_DIV  = 3'd4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 3'd0,
    OP_INT  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } op_e;

  // Per-unit status record
  typedef struct packed {
    logic            busy;
    logic [OP_W-1:0] op;
    reg_t            fi;
    reg_t            fj;
    reg_t            fk;
    tag_t            qj;
    tag_t            qk;
    logic            rj;
    logic            rk;
  } unit_rec_t;

  // Writer code stored in the result table: 0 means none
  function automatic tag_t unit_tag(input int u);
    return tag_t'(u + 1);
  endfunction
endpackage

// File: rtl/sb_unit_sel.sv
`timescale 1ns/1ps
module sb_unit_sel
  import sb_pkg::*;
(
  input  logic [OP_W-1:0]      op,
  input  logic [NUM_UNITS-1:0] busy,
  output uidx_t                unit_idx,
  output logic                 known
);
  always_comb begin
    known    = 1'b1;
    unit_idx = U_INT;
    case (op)
      OP_LOAD, OP_INT: unit_idx = U_INT;
      OP_ADD, OP_SUB:  unit_idx = U_ADD;
      OP_MUL:          unit_idx = (!busy[U_MUL1] || busy[U_MUL2]) ? U_MUL1 : U_MUL2;
      OP_DIV:          unit_idx = U_DIV;
      default:         known    = 1'b0;
    endcase
  end
endmodule

// File: rtl/sb_latency.sv
`timescale 1ns/1ps
module sb_latency #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic finish,
  output logic done
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = CW'(LAT - 1);
    end else if (finish) begin
      run_d = 1'b0;
    end else if (run_q && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign done = run_q && (cnt_q == '0);
endmodule

// File: rtl/sb_result_table.sv
`timescale 1ns/1ps
module sb_result_table
  import sb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  reg_t                 set_reg,
  input  tag_t                 set_tag,
  input  logic [NUM_UNITS-1:0] clr_en,
  input  reg_t                 clr_reg  [NUM_UNITS],
  input  reg_t                 look_reg [NLOOK],
  output tag_t                 look_tag [NLOOK]
);
  tag_t tab_q [NUM_REGS];
  tag_t tab_d [NUM_REGS];

  always_comb begin
    tab_d = tab_q;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (clr_en[u] && (tab_q[clr_reg[u]] == unit_tag(u))) tab_d[clr_reg[u]] = '0;
    end
    if (set_en) tab_d[set_reg] = set_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) tab_q[r] <= '0;
    end else begin
      tab_q <= tab_d;
    end
  end

  generate
    for (genvar l = 0; l < NLOOK; l++) begin : g_look
      assign look_tag[l] = tab_q[look_reg[l]];
    end
  endgenerate
endmodule

// File: rtl/sb_ctrl.sv
`timescale 1ns/1ps
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      in_op,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src1,
  input  logic [REG_W-1:0]     in_src2,
  output logic                 issue_ok,
  output logic [UIDX_W-1:0]    issue_unit,
  output logic [NUM_UNITS-1:0] rd_grant,
  output logic [NUM_UNITS-1:0] wr_grant,
  output logic [NUM_UNITS-1:0] unit_busy,
  output logic [NUM_UNITS-1:0] ready_j,
  output logic [NUM_UNITS-1:0] ready_k,
  input  logic [REG_W-1:0]     qry_reg,
  output logic [TAG_W-1:0]     qry_writer
);
  unit_rec_t rec_q [NUM_UNITS];
  unit_rec_t rec_d [NUM_UNITS];

  logic [NUM_UNITS-1:0] done;
  logic [NUM_UNITS-1:0] war;
  uidx_t                sel_unit;
  logic                 sel_known;
  reg_t                 look_reg [NLOOK];
  tag_t                 look_tag [NLOOK];
  reg_t                 fi_vec   [NUM_UNITS];
  tag_t                 src_tag_j, src_tag_k;

  // Status vectors
  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_stat
      assign unit_busy[u] = rec_q[u].busy;
      assign ready_j[u]   = rec_q[u].rj;
      assign ready_k[u]   = rec_q[u].rk;
      assign fi_vec[u]    = rec_q[u].fi;
    end
  endgenerate

  sb_unit_sel u_sel (
    .op       (in_op),
    .busy     (unit_busy),
    .unit_idx (sel_unit),
    .known    (sel_known)
  );

  assign look_reg[0] = in_dst;
  assign look_reg[1] = in_src1;
  assign look_reg[2] = in_src2;
  assign look_reg[3] = qry_reg;

  sb_result_table u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (issue_ok),
    .set_reg  (in_dst),
    .set_tag  (unit_tag(int'(sel_unit))),
    .clr_en   (wr_grant),
    .clr_reg  (fi_vec),
    .look_reg (look_reg),
    .look_tag (look_tag)
  );

  // Completion timers, one per unit with its own latency
  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int L = (u == int'(U_INT)) ? LAT_INT :
                         (u == int'(U_ADD)) ? LAT_ADD :
                         (u == int'(U_DIV)) ? LAT_DIV : LAT_MUL;
      sb_latency #(.LAT(L)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rd_grant[u]),
        .finish (wr_grant[u]),
        .done   (done[u])
      );
    end
  endgenerate

  // WAR hazard: another unit still has to read the old value of our target
  always_comb begin
    war = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      for (int f = 0; f < NUM_UNITS; f++) begin
        if (f != u && rec_q[f].busy &&
            ((rec_q[f].fj == rec_q[u].fi && rec_q[f].rj) ||
             (rec_q[f].fk == rec_q[u].fi && rec_q[f].rk)))
          war[u] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      rd_grant[u] = rec_q[u].busy && rec_q[u].rj && rec_q[u].rk;
      wr_grant[u] = rec_q[u].busy && done[u] && !war[u];
    end
  end

  // Issue: unit free and no pending writer of the destination
  assign issue_ok   = in_valid && sel_known && !unit_busy[sel_unit] && (look_tag[0] == '0);
  assign issue_unit = sel_unit;
  assign qry_writer = look_tag[3];

  // Source producers, dropping a producer that writes back this cycle
  always_comb begin
    src_tag_j = look_tag[1];
    src_tag_k = look_tag[2];
    for (int w = 0; w < NUM_UNITS; w++) begin
      if (wr_grant[w] && src_tag_j == unit_tag(w)) src_tag_j = '0;
      if (wr_grant[w] && src_tag_k == unit_tag(w)) src_tag_k = '0;
    end
  end

  // Record next state
  always_comb begin
    rec_d = rec_q;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (wr_grant[u]) rec_d[u].busy = 1'b0;
      if (rd_grant[u]) begin
        rec_d[u].rj = 1'b0;
        rec_d[u].rk = 1'b0;
      end
      for (int w = 0; w < NUM_UNITS; w++) begin
        if (wr_grant[w] && rec_q[u].qj == unit_tag(w)) begin
          rec_d[u].qj = '0;
          rec_d[u].rj = 1'b1;
        end
        if (wr_grant[w] && rec_q[u].qk == unit_tag(w)) begin
          rec_d[u].qk = '0;
          rec_d[u].rk = 1'b1;
        end
      end
    end
    if (issue_ok) begin
      rec_d[sel_unit].busy = 1'b1;
      rec_d[sel_unit].op   = in_op;
      rec_d[sel_unit].fi   = in_dst;
      rec_d[sel_unit].fj   = in_src1;
      rec_d[sel_unit].fk   = in_src2;
      rec_d[sel_unit].qj   = src_tag_j;
      rec_d[sel_unit].qk   = src_tag_k;
      rec_d[sel_unit].rj   = (src_tag_j == '0);
      rec_d[sel_unit].rk   = (src_tag_k == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NUM_UNITS; u++) rec_q[u] <= '0;
    end else begin
      rec_q <= rec_d;
    end
  end
endmodule

// File: rtl/sb_ctrl_chk.sv
`timescale 1ns/1ps
module sb_ctrl_chk
  import sb_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 issue_ok,
  input logic [UIDX_W-1:0]    issue_unit,
  input logic [NUM_UNITS-1:0] rd_grant,
  input logic [NUM_UNITS-1:0] wr_grant,
  input logic [NUM_UNITS-1:0] unit_busy,
  input logic [NUM_UNITS-1:0] ready_j,
  input logic [NUM_UNITS-1:0] ready_k
);
  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
      localparam int L = (u == int'(U_INT)) ? LAT_INT :
                         (u == int'(U_ADD)) ? LAT_ADD :
                         (u == int'(U_DIV)) ? LAT_DIV : LAT_MUL;

      a_r2_issue_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && issue_unit == UIDX_W'(u)) |=> unit_busy[u]);

      a_r5_read_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant[u] |=> (!ready_j[u] && !ready_k[u] && unit_busy[u]));

      a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant[u] |=> !rd_grant[u]);

      if (L > 1) begin : g_slow
        a_r6_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
          rd_grant[u] |=> !wr_grant[u]);
      end

      a_r8_write_frees_unit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant[u] |=> !unit_busy[u]);

      a_r8_idle_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_busy[u] |-> (!ready_j[u] && !ready_k[u]));

      a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant[u] |-> (!ready_j[u] && !ready_k[u]));
    end
  endgenerate
endmodule

bind sb_ctrl sb_ctrl_chk #(
  .LAT_INT (LAT_INT),
  .LAT_ADD (LAT_ADD),
  .LAT_MUL (LAT_MUL),
  .LAT_DIV (LAT_DIV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_ok   (issue_ok),
  .issue_unit (issue_unit),
  .rd_grant   (rd_grant),
  .wr_grant   (wr_grant),
  .unit_busy  (unit_busy),
  .ready_j    (ready_j),
  .ready_k    (ready_k)
);

// File: tb/sb_ctrl_tb.sv
`timescale 1ns/1ps
module sb_ctrl_tb;
  localparam int NU = 5;
  localparam int PROG = 2400;

  logic       clk, rst_n, in_valid;
  logic [2:0] in_op;
  logic [4:0] in_dst, in_src1, in_src2, qry_reg;
  logic       issue_ok;
  logic [2:0] issue_unit, qry_writer;
  logic [4:0] rd_grant, wr_grant, unit_busy, ready_j, ready_k;

  sb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .issue_ok(issue_ok), .issue_unit(issue_unit), .rd_grant(rd_grant),
    .wr_grant(wr_grant), .unit_busy(unit_busy), .ready_j(ready_j),
    .ready_k(ready_k), .qry_reg(qry_reg), .qry_writer(qry_writer)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks, errors, cyc;
  int p_op[PROG], p_dst[PROG], p_s1[PROG], p_s2[PROG];
  int p, pend;
  bit running, bubbles;

  // Reference state built from the requirements
  bit m_busy[NU], m_rj[NU], m_rk[NU], m_exec[NU];
  int m_fi[NU], m_fj[NU], m_fk[NU], m_qj[NU], m_qk[NU], m_cnt[NU];
  int m_tab[32];
  int war_seen, waw_seen, mul2_seen, wake_seen, multi_wr_seen, struct_seen;

  function automatic int lat_of(input int u);
    case (u)
      0: return 1;
      3: return 2;
      4: return 40;
      default: return 10;
    endcase
  endfunction

  function automatic int sel_of(input int op);
    case (op)
      0, 1: return 0;
      2, 3: return 3;
      4: return (!m_busy[1] || m_busy[2]) ? 1 : 2;
      5: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit model_idle();
    for (int u = 0; u < NU; u++) if (m_busy[u]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic eval_cycle();
    int sel, tj, tk, nw;
    bit e_iss, war;
    bit [4:0] e_rd, e_wr, e_busy, e_rj, e_rk;
    bit n_busy[NU], n_rj[NU], n_rk[NU], n_exec[NU];
    int n_fi[NU], n_fj[NU], n_fk[NU], n_qj[NU], n_qk[NU], n_cnt[NU], n_tab[32];

    sel   = sel_of(int'(in_op));
    e_iss = in_valid && sel >= 0 && !m_busy[sel] && m_tab[in_dst] == 0;
    if (in_valid && sel >= 0 && !m_busy[sel] && m_tab[in_dst] != 0) waw_seen++;
    if (in_valid && sel >= 0 && m_busy[sel]) struct_seen++;
    nw = 0;
    for (int u = 0; u < NU; u++) begin
      e_rd[u] = m_busy[u] && m_rj[u] && m_rk[u];
      war = 1'b0;
      for (int f = 0; f < NU; f++)
        if (f != u && m_busy[f] && ((m_fj[f] == m_fi[u] && m_rj[f]) || (m_fk[f] == m_fi[u] && m_rk[f])))
          war = 1'b1;
      e_wr[u] = m_busy[u] && m_exec[u] && m_cnt[u] == 0 && !war;
      if (m_busy[u] && m_exec[u] && m_cnt[u] == 0 && war) war_seen++;
      if (e_wr[u]) nw++;
      e_busy[u] = m_busy[u]; e_rj[u] = m_rj[u]; e_rk[u] = m_rk[u];
    end
    if (nw > 1) multi_wr_seen++;

    check(issue_ok == e_iss, "R2/R3 issue_ok", issue_ok, e_iss);
    if (e_iss) check(int'(issue_unit) == sel, "R4 issue_unit", issue_unit, sel);
    check(rd_grant == e_rd, "R5 rd_grant", rd_grant, e_rd);
    check(wr_grant == e_wr, "R6 R7 wr_grant", wr_grant, e_wr);
    check(unit_busy == e_busy, "R8 unit_busy", unit_busy, e_busy);
    check(ready_j == e_rj && ready_k == e_rk, "R5 R8 ready flags",
          {ready_j, ready_k}, {e_rj, e_rk});
    check(int'(qry_writer) == m_tab[qry_reg], "R8 qry_writer", qry_writer, m_tab[qry_reg]);

    n_busy = m_busy; n_rj = m_rj; n_rk = m_rk; n_exec = m_exec;
    n_fi = m_fi; n_fj = m_fj; n_fk = m_fk; n_qj = m_qj; n_qk = m_qk;
    n_cnt = m_cnt; n_tab = m_tab;
    for (int u = 0; u < NU; u++) begin
      if (e_wr[u]) begin
        n_busy[u] = 0; n_exec[u] = 0;
        if (n_tab[m_fi[u]] == u + 1) n_tab[m_fi[u]] = 0;
      end
      if (e_rd[u]) begin
        n_rj[u] = 0; n_rk[u] = 0; n_exec[u] = 1; n_cnt[u] = lat_of(u) - 1;
      end else if (m_exec[u] && m_cnt[u] > 0) begin
        n_cnt[u] = m_cnt[u] - 1;
      end
      for (int w = 0; w < NU; w++) begin
        if (e_wr[w] && m_qj[u] == w + 1) begin n_qj[u] = 0; n_rj[u] = 1; end
        if (e_wr[w] && m_qk[u] == w + 1) begin n_qk[u] = 0; n_rk[u] = 1; end
      end
    end
    if (e_iss) begin
      tj = m_tab[in_src1];
      tk = m_tab[in_src2];
      if (tj != 0 && e_wr[tj-1]) begin tj = 0; wake_seen++; end
      if (tk != 0 && e_wr[tk-1]) begin tk = 0; wake_seen++; end
      n_busy[sel] = 1; n_fi[sel] = in_dst; n_fj[sel] = in_src1; n_fk[sel] = in_src2;
      n_qj[sel] = tj; n_qk[sel] = tk; n_rj[sel] = (tj == 0); n_rk[sel] = (tk == 0);
      n_exec[sel] = 0; n_tab[in_dst] = sel + 1;
      if (sel == 2) mul2_seen++;
      p++;
    end
    m_busy = n_busy; m_rj = n_rj; m_rk = n_rk; m_exec = n_exec;
    m_fi = n_fi; m_fj = n_fj; m_fk = n_fk; m_qj = n_qj; m_qk = n_qk;
    m_cnt = n_cnt; m_tab = n_tab;
  endtask

  always @(negedge clk) begin
    if (running) begin
      in_valid = (p < pend) && (!bubbles || ($urandom % 8) != 0);
      if (p < pend) begin
        in_op = 3'(p_op[p]); in_dst = 5'(p_dst[p]);
        in_src1 = 5'(p_s1[p]); in_src2 = 5'(p_s2[p]);
      end
      qry_reg = 5'($urandom % 16);
      #1;
      eval_cycle();
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  task automatic set_ins(input int i, input int op, input int d, input int a, input int b);
    p_op[i] = op; p_dst[i] = d; p_s1[i] = a; p_s2[i] = b;
  endtask

  task automatic drain();
    do @(posedge clk); while (!(p == pend && model_idle()));
  endtask

  initial begin
    void'($urandom(32'h5C0E_B0A7));
    checks = 0; errors = 0; cyc = 0; p = 0; pend = 0;
    running = 0; bubbles = 0;
    rst_n = 0; in_valid = 0; in_op = 0; in_dst = 0; in_src1 = 0; in_src2 = 0; qry_reg = 0;
    for (int u = 0; u < NU; u++) begin
      m_busy[u] = 0; m_rj[u] = 0; m_rk[u] = 0; m_exec[u] = 0;
      m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_qj[u] = 0; m_qk[u] = 0; m_cnt[u] = 0;
    end
    for (int r = 0; r < 32; r++) m_tab[r] = 0;

    // Directed: dependent chain with RAW, WAR, WAW, structural, spare multiplier
    set_ins(0, 0, 6, 20, 20);
    set_ins(1, 0, 2, 21, 21);
    set_ins(2, 4, 0, 2, 4);
    set_ins(3, 3, 8, 6, 2);
    set_ins(4, 5, 10, 0, 6);
    set_ins(5, 2, 6, 8, 2);
    set_ins(6, 4, 12, 14, 14);
    set_ins(7, 1, 10, 1, 1);
    // Directed: consumer issues in its producer's write-back cycle (R9)
    set_ins(8, 1, 3, 22, 22);
    set_ins(9, 2, 25, 23, 23);
    set_ins(10, 4, 26, 3, 25);
    for (int i = 11; i < PROG; i++)
      set_ins(i, int'($urandom % 6), int'($urandom % 12), int'($urandom % 12), int'($urandom % 12));

    repeat (3) @(posedge clk);
    // R1: outputs idle while in reset
    #1;
    check(unit_busy == 0 && rd_grant == 0 && wr_grant == 0, "R1 idle in reset",
          {unit_busy, rd_grant, wr_grant}, 0);
    @(negedge clk); rst_n = 1;
    #1;
    for (int r = 0; r < 4; r++) begin
      qry_reg = 5'(r * 7); #0.2;
      check(qry_writer == 0, "R1 table empty after reset", qry_writer, 0);
    end
    check(unit_busy == 0 && ready_j == 0 && ready_k == 0 && issue_ok == 0,
          "R1 records clear after reset", {unit_busy, ready_j, ready_k}, 0);

    pend = 8;  running = 1; drain();
    pend = 11; drain();
    bubbles = 1; pend = PROG; drain();
    @(negedge clk); running = 0;

    check(war_seen > 0, "R7 WAR hold exercised", war_seen, 1);
    check(waw_seen > 0, "R3 WAW hold exercised", waw_seen, 1);
    check(mul2_seen > 0, "R4 second multiplier used", mul2_seen, 1);
    check(wake_seen > 0, "R9 same-cycle wakeup exercised", wake_seen, 1);
    check(multi_wr_seen > 0, "R10 parallel write-backs exercised", multi_wr_seen, 1);
    check(struct_seen > 0, "R2 busy-unit hold exercised", struct_seen, 1);
    check(p == PROG, "R2 whole stream issued in order", p, PROG);
    summary();
  end
endmodule